// File: doc/BRIEF.md
# Byte-Wide Multicycle Teaching Processor Core

This block is a small multicycle processor for an 8-bit datapath. Each instruction is 16 bits long and is fetched as two bytes from a private 256-byte memory into an instruction register. The core then decodes the instruction and executes it on a bank of sixteen 8-bit registers. The instruction set has memory and immediate loads, a store, a register copy, a two's-complement add, the three bitwise logic operations, a circular right rotate by an immediate count, a jump taken when a register matches register 0, and a halt. Opcode 6 is a floating-point add. The core does not compute it: it drives the two source registers to an external adder and writes that adder's byte back to the destination register.

A host or testbench fills the memory through a preload write port. This is normally done while reset is held, because the memory itself is not reset. The host then releases reset and waits for the halted flag. A combinational debug port shows the register selected by a 4-bit index, which gives a view of the results without disturbing execution.

Top module: `nib_cpu_core`

## Requirements
- R1: Reset clears all sixteen registers to 00, sets the program counter to 00 and deasserts `halted`.
- R2: The byte at the even address is the instruction's high byte and the next byte is the low byte. The program counter advances by 2 per fetch. Non-memory instructions take 4 clock cycles and opcodes 1 and 3 take 5 cycles, so `halted` rises on the 8th rising edge after reset release for a program of one register instruction followed by a halt.
- R3: Opcode 1 (hex word 1RXY) loads register R with memory[XY]. Opcode 2 (2RXY) loads register R with the constant XY.
- R4: Opcode 3 (3RXY) writes register R into memory[XY], and the memory is written at no other time by the core.
- R5: Opcode 4 (4ARS) copies register R (bits 7:4) into register S (bits 3:0), and the nibble A (bits 11:8) has no effect.
- R6: Opcode 5 (5RST) writes R with S+T modulo 256.
- R7: Opcodes 7, 8 and 9 (RST) write R with S OR T, S AND T and S XOR T.
- R8: Opcode A (ARNX) rotates register R right X times circularly, using the count X modulo 8, and the nibble N has no effect.
- R9: Opcode B (BRXY) sets the program counter to XY when register R equals register 0 and otherwise falls through, so B0XY always jumps.
- R10: Opcode C halts. `halted` then stays high, and registers, memory and the program counter hold until reset.
- R11: Opcode 6 (6RST) drives register S on `fadd_a` and register T on `fadd_b`, and writes `fadd_y` into register R.
- R12: Opcodes 0, D, E and F change no register and no memory.
- R13: The program counter wraps from FE to 00 after fetching the instruction at FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_we | input | 1 | Preload write strobe into memory |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_data | output | 8 | Contents of the selected register |
| halted | output | 1 | High once a halt has executed |
| fadd_a | output | 8 | First operand to the external float adder |
| fadd_b | output | 8 | Second operand to the external float adder |
| fadd_y | input | 8 | Result from the external float adder |

## Verification
The bench covers four corner cases.

- Add overflow: an add that crosses 7F to 80 and one that wraps to 00 would show a wrong byte if the carry were kept or the width were off.
- Rotate counts: counts of 3, 9 and 8 check that the count is taken modulo 8. A shift instead of a rotate would lose the low bits, and a count taken as zero when it is 8 or more would give the wrong pattern.
- Jump cases: a jump that is not taken, a taken conditional jump and an unconditional jump through register 0 each leave marker registers set or untouched. A swapped comparison or a missing fall-through would change those markers.
- Wrap and halt: a program placed at FE that wraps to 00 tests the modulo-256 program counter. Counting cycles to halt exposes a sequencer with a missing or extra state.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

   typedef enum logic [2:0] {
      ST_FH   = 3'd0,
      ST_FL   = 3'd1,
      ST_DEC  = 3'd2,
      ST_EXE  = 3'd3,
      ST_MEM  = 3'd4,
      ST_HALT = 3'd5
   } seq_state_t;

   typedef enum logic [3:0] {
      OP_NOP0 = 4'h0,
      OP_LDM  = 4'h1,
      OP_LDI  = 4'h2,
      OP_STM  = 4'h3,
      OP_MOV  = 4'h4,
      OP_ADD  = 4'h5,
      OP_FADD = 4'h6,
      OP_OR   = 4'h7,
      OP_AND  = 4'h8,
      OP_XOR  = 4'h9,
      OP_ROR  = 4'hA,
      OP_JEQ  = 4'hB,
      OP_HLT  = 4'hC
   } opcode_t;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_OR  = 3'd1,
      ALU_AND = 3'd2,
      ALU_XOR = 3'd3,
      ALU_ROR = 3'd4
   } alu_op_t;

endpackage

// File: rtl/nib_mem.sv
module nib_mem #(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          pre_we,
   input  logic [AW-1:0] pre_addr,
   input  logic [DW-1:0] pre_wdata,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (pre_we) begin
         cells[pre_addr] <= pre_wdata;
      end else if (cpu_we) begin
         cells[cpu_addr] <= cpu_wdata;
      end
      rdata <= cells[cpu_addr];
   end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
   parameter int DW   = 8,
   parameter int NREG = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [$clog2(NREG)-1:0] ra_addr,
   output logic [DW-1:0]           ra_data,
   input  logic [$clog2(NREG)-1:0] rb_addr,
   output logic [DW-1:0]           rb_data,
   input  logic [$clog2(NREG)-1:0] rd_addr,
   output logic [DW-1:0]           rd_data
);
   localparam int RSW = $clog2(NREG);

   logic [DW-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (we && waddr == RSW'(i)) begin
            r_q <= wdata;
         end
      end
      assign bank[i] = r_q;
   end

   assign ra_data = bank[ra_addr];
   assign rb_data = bank[rb_addr];
   assign rd_data = bank[rd_addr];
endmodule

// File: rtl/nib_alu.sv
module nib_alu
   import nib_cpu_pkg::*;
#(
   parameter int DW       = 8,
   parameter int ROT_IMPL = 1
) (
   input  alu_op_t              op,
   input  logic [DW-1:0]        a,
   input  logic [DW-1:0]        b,
   input  logic [$clog2(DW)-1:0] amt,
   output logic [DW-1:0]        y
);
   localparam int LG = $clog2(DW);

   if ((1 << LG) != DW) begin : g_chk_pow2
      $error("nib_alu: DW must be a power of two");
   end

   logic [DW-1:0] rot_y;

   if (ROT_IMPL == 0) begin : g_rot_concat
      assign rot_y = DW'({a, a} >> amt);
   end else begin : g_rot_barrel
      logic [DW-1:0] stg [LG+1];
      assign stg[0] = a;
      for (genvar k = 0; k < LG; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = amt[k] ? {stg[k][SH-1:0], stg[k][DW-1:SH]} : stg[k];
      end
      assign rot_y = stg[LG];
   end

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_OR:  y = a | b;
         ALU_AND: y = a & b;
         ALU_XOR: y = a ^ b;
         ALU_ROR: y = rot_y;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/nib_seq.sv
module nib_seq
   import nib_cpu_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] mem_rdata,
   input  logic          jump_take,
   output seq_state_t    state,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] ir_hi,
   output logic [DW-1:0] ir_lo
);
   logic [3:0] op;
   assign op = ir_hi[DW-1 -: 4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_FH;
         pc    <= '0;
         ir_hi <= '0;
         ir_lo <= '0;
      end else begin
         case (state)
            ST_FH: state <= ST_FL;
            ST_FL: begin
               ir_hi <= mem_rdata;
               state <= ST_DEC;
            end
            ST_DEC: begin
               ir_lo <= mem_rdata;
               pc    <= pc + AW'(2);
               state <= ST_EXE;
            end
            ST_EXE: begin
               if (jump_take) begin
                  pc <= AW'(ir_lo);
               end
               if (op == OP_HLT) begin
                  state <= ST_HALT;
               end else if (op == OP_LDM || op == OP_STM) begin
                  state <= ST_MEM;
               end else begin
                  state <= ST_FH;
               end
            end
            ST_MEM:  state <= ST_FH;
            ST_HALT: state <= ST_HALT;
            default: state <= ST_FH;
         endcase
      end
   end
endmodule

// File: rtl/nib_cpu_core.sv
module nib_cpu_core
   import nib_cpu_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 8,
   parameter int NREG     = 16,
   parameter int ROT_IMPL = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pre_we,
   input  logic [7:0]    pre_addr,
   input  logic [7:0]    pre_data,
   input  logic [3:0]    dbg_sel,
   output logic [7:0]    dbg_data,
   output logic          halted,
   output logic [7:0]    fadd_a,
   output logic [7:0]    fadd_b,
   input  logic [7:0]    fadd_y
);
   localparam int IW  = 2 * DW;
   localparam int RSW = $clog2(NREG);
   localparam int OPW = 4;
   localparam int LG  = $clog2(DW);

   if (OPW + 3 * RSW != IW) begin : g_chk_fmt
      $error("nib_cpu_core: opcode plus three register fields must fill the instruction");
   end
   if (AW != DW) begin : g_chk_addr
      $error("nib_cpu_core: the byte operand must span the address space");
   end
   if (DW != 8 || RSW != 4) begin : g_chk_ports
      $error("nib_cpu_core: port widths assume 8-bit data and 16 registers");
   end

   seq_state_t    state;
   logic [AW-1:0] pc;
   logic [DW-1:0] ir_hi, ir_lo;
   logic [IW-1:0] ir;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic          jump_take;

   logic [3:0]     op;
   logic [RSW-1:0] f_r, f_s, f_t;
   logic [DW-1:0]  f_xy;

   logic [RSW-1:0] ra_sel, rb_sel, rf_waddr;
   logic [DW-1:0]  ra_data, rb_data, rf_wdata, alu_y;
   logic           rf_we;
   alu_op_t        alu_op;

   assign ir   = {ir_hi, ir_lo};
   assign op   = ir[IW-1 -: OPW];
   assign f_r  = ir[3*RSW-1 -: RSW];
   assign f_s  = ir[2*RSW-1 -: RSW];
   assign f_t  = ir[RSW-1:0];
   assign f_xy = ir[DW-1:0];

   nib_seq #(.DW(DW), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_rdata (mem_rdata),
      .jump_take (jump_take),
      .state     (state),
      .pc        (pc),
      .ir_hi     (ir_hi),
      .ir_lo     (ir_lo)
   );

   always_comb begin
      if (state == ST_EXE || state == ST_MEM) begin
         mem_addr = AW'(f_xy);
      end else if (state == ST_FL) begin
         mem_addr = pc + AW'(1);
      end else begin
         mem_addr = pc;
      end
   end

   assign mem_we = (state == ST_MEM) && (op == OP_STM);

   nib_mem #(.DW(DW), .AW(AW)) u_mem (
      .clk       (clk),
      .pre_we    (pre_we),
      .pre_addr  (AW'(pre_addr)),
      .pre_wdata (DW'(pre_data)),
      .cpu_we    (mem_we),
      .cpu_addr  (mem_addr),
      .cpu_wdata (ra_data),
      .rdata     (mem_rdata)
   );

   always_comb begin
      ra_sel = f_r;
      rb_sel = f_t;
      alu_op = ALU_ADD;
      case (op)
         OP_MOV, OP_ADD, OP_FADD: ra_sel = f_s;
         OP_OR:  begin ra_sel = f_s; alu_op = ALU_OR;  end
         OP_AND: begin ra_sel = f_s; alu_op = ALU_AND; end
         OP_XOR: begin ra_sel = f_s; alu_op = ALU_XOR; end
         OP_ROR: alu_op = ALU_ROR;
         OP_JEQ: rb_sel = '0;
         default: ;
      endcase
   end

   always_comb begin
      rf_we    = 1'b0;
      rf_waddr = f_r;
      rf_wdata = alu_y;
      if (state == ST_EXE) begin
         case (op)
            OP_LDI: begin rf_we = 1'b1; rf_wdata = f_xy; end
            OP_MOV: begin rf_we = 1'b1; rf_waddr = f_t; rf_wdata = ra_data; end
            OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
            OP_FADD: begin rf_we = 1'b1; rf_wdata = DW'(fadd_y); end
            default: ;
         endcase
      end else if (state == ST_MEM && op == OP_LDM) begin
         rf_we    = 1'b1;
         rf_wdata = mem_rdata;
      end
   end

   logic [DW-1:0] dbg_q;

   nib_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .ra_addr (ra_sel),
      .ra_data (ra_data),
      .rb_addr (rb_sel),
      .rb_data (rb_data),
      .rd_addr (RSW'(dbg_sel)),
      .rd_data (dbg_q)
   );

   nib_alu #(.DW(DW), .ROT_IMPL(ROT_IMPL)) u_alu (
      .op  (alu_op),
      .a   (ra_data),
      .b   (rb_data),
      .amt (f_t[LG-1:0]),
      .y   (alu_y)
   );

   assign jump_take = (state == ST_EXE) && (op == OP_JEQ) && (ra_data == rb_data);
   assign halted    = (state == ST_HALT);
   assign dbg_data  = 8'(dbg_q);
   assign fadd_a    = 8'(ra_data);
   assign fadd_b    = 8'(rb_data);
endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk
   import nib_cpu_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input seq_state_t    state,
   input logic [AW-1:0] pc,
   input logic [3:0]    op,
   input logic          rf_we,
   input logic          mem_we,
   input logic          halted
);
   a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == '0 && state == ST_FH && !halted));

   a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_FH |=> state == ST_FL);

   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DEC |=> pc == AW'($past(pc) + AW'(2)));

   a_r4_store_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (state == ST_MEM && op == OP_STM));

   a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(pc) && !rf_we && !mem_we));

   a_r12_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXE && (op == 4'h0 || op == 4'hD || op == 4'hE || op == 4'hF))
      |-> (!rf_we && !mem_we));
endmodule

bind nib_cpu_core nib_cpu_chk #(.AW(AW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .state  (state),
   .pc     (pc),
   .op     (op),
   .rf_we  (rf_we),
   .mem_we (mem_we),
   .halted (halted)
);

// File: tb/sim_nib_cpu_core.sv
`timescale 1ns/100ps
module sim_nib_cpu_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pre_we = 1'b0;
   logic [7:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic [3:0] dbg_sel = '0;
   logic [7:0] dbg_data;
   logic       halted;
   logic [7:0] fadd_a, fadd_b, fadd_y;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign fadd_y = {fadd_a[7:4], fadd_b[3:0]};

   nib_cpu_core u0 (
      .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
      .halted(halted), .fadd_a(fadd_a), .fadd_b(fadd_b), .fadd_y(fadd_y)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic put_b(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = a; pre_data = d;
   endtask

   task automatic put_w(input logic [7:0] a, input logic [15:0] w);
      put_b(a, w[15:8]);
      put_b(a + 8'd1, w[7:0]);
   endtask

   task automatic begin_prog();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) put_b(8'(i), 8'h00);
   endtask

   task automatic run(output int edges);
      @(negedge clk);
      pre_we = 1'b0;
      rst_n = 1'b1;
      edges = 0;
      while (!halted && edges < 3000) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
      end
   endtask

   task automatic reg_is(input string tag, input int idx, input int exp);
      @(negedge clk);
      dbg_sel = 4'(idx);
      #1;
      check(tag, int'(dbg_data), exp);
   endtask

   function automatic logic [7:0] ror8(input logic [7:0] v, input int n);
      logic [7:0] r = v;
      for (int i = 0; i < (n % 8); i++) r = {r[0], r[7:1]};
      return r;
   endfunction

   task automatic t_load();
      int e;
      begin_prog();
      put_w(8'h00, 16'h1540); put_w(8'h02, 16'h26A3); put_w(8'h04, 16'hC000);
      put_b(8'h40, 8'h7E);
      run(e);
      check("R2 load program cycles", e, 13);
      reg_is("R3 memory load r5", 5, 8'h7E);
      reg_is("R3 immediate load r6", 6, 8'hA3);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 halted low in reset", int'(halted), 0);
      for (int i = 0; i < 16; i++) reg_is("R1 register cleared", i, 0);
   endtask

   task automatic t_store();
      int e;
      begin_prog();
      put_w(8'h00, 16'h219C); put_w(8'h02, 16'h3150);
      put_w(8'h04, 16'h1250); put_w(8'h06, 16'hC000);
      run(e);
      reg_is("R4 stored byte read back", 2, 8'h9C);
      reg_is("R4 source kept", 1, 8'h9C);
      check("R10 halted after store", int'(halted), 1);
   endtask

   task automatic t_move();
      int e;
      begin_prog();
      put_w(8'h00, 16'h213C); put_w(8'h02, 16'h4A12); put_w(8'h04, 16'hC000);
      run(e);
      reg_is("R5 move destination", 2, 8'h3C);
      reg_is("R5 move source", 1, 8'h3C);
      reg_is("R5 leading nibble register untouched", 10, 0);
   endtask

   task automatic t_add();
      int e;
      begin_prog();
      put_w(8'h00, 16'h217F); put_w(8'h02, 16'h2201); put_w(8'h04, 16'h5312);
      put_w(8'h06, 16'h24FF); put_w(8'h08, 16'h5542); put_w(8'h0A, 16'hC000);
      run(e);
      reg_is("R6 add 7F+01", 3, 8'h80);
      reg_is("R6 add FF+01 wraps", 5, 8'h00);
   endtask

   task automatic t_logic();
      int e;
      begin_prog();
      put_w(8'h00, 16'h21C5); put_w(8'h02, 16'h225A);
      put_w(8'h04, 16'h7312); put_w(8'h06, 16'h8412); put_w(8'h08, 16'h9512);
      put_w(8'h0A, 16'hC000);
      run(e);
      reg_is("R7 or", 3, 8'hC5 | 8'h5A);
      reg_is("R7 and", 4, 8'hC5 & 8'h5A);
      reg_is("R7 xor", 5, 8'hC5 ^ 8'h5A);
   endtask

   task automatic t_rot();
      int e;
      begin_prog();
      put_w(8'h00, 16'h2196); put_w(8'h02, 16'h2296); put_w(8'h04, 16'h2396);
      put_w(8'h06, 16'hA103); put_w(8'h08, 16'hA209); put_w(8'h0A, 16'hA358);
      put_w(8'h0C, 16'hC000);
      run(e);
      reg_is("R8 rotate by 3", 1, ror8(8'h96, 3));
      reg_is("R8 rotate by 9", 2, ror8(8'h96, 9));
      reg_is("R8 rotate by 8 middle nibble ignored", 3, ror8(8'h96, 8));
   endtask

   task automatic t_jump();
      int e;
      begin_prog();
      put_w(8'h00, 16'h2005); put_w(8'h02, 16'h2105); put_w(8'h04, 16'h2206);
      put_w(8'h06, 16'hB20C); put_w(8'h08, 16'h2311); put_w(8'h0A, 16'hB110);
      put_w(8'h0C, 16'h2422); put_w(8'h0E, 16'hC000); put_w(8'h10, 16'h2533);
      put_w(8'h12, 16'hB016); put_w(8'h14, 16'h2644); put_w(8'h16, 16'hC000);
      run(e);
      reg_is("R9 untaken jump falls through", 3, 8'h11);
      reg_is("R9 taken jump skips", 4, 8'h00);
      reg_is("R9 jump target runs", 5, 8'h33);
      reg_is("R9 unconditional jump skips", 6, 8'h00);
   endtask

   task automatic t_halt();
      int e;
      begin_prog();
      put_w(8'h00, 16'h210A); put_w(8'h02, 16'hC000); put_w(8'h04, 16'h2155);
      run(e);
      check("R2 cycles to halt", e, 8);
      repeat (40) @(negedge clk);
      check("R10 halted held", int'(halted), 1);
      reg_is("R10 state held after halt", 1, 8'h0A);
   endtask

   task automatic t_float();
      int e;
      begin_prog();
      put_w(8'h00, 16'h2112); put_w(8'h02, 16'h2234); put_w(8'h04, 16'h6312);
      put_w(8'h06, 16'hC000);
      run(e);
      reg_is("R11 float result written", 3, {4'h1, 4'h4});
   endtask

   task automatic t_nop();
      int e;
      begin_prog();
      put_w(8'h00, 16'h2177); put_w(8'h02, 16'h0123); put_w(8'h04, 16'hD1FF);
      put_w(8'h06, 16'hE100); put_w(8'h08, 16'hF112); put_w(8'h0A, 16'hC000);
      run(e);
      check("R12 nop program reaches halt", int'(halted), 1);
      reg_is("R12 r1 unchanged", 1, 8'h77);
      reg_is("R12 r2 unchanged", 2, 8'h00);
      reg_is("R12 r3 unchanged", 3, 8'h00);
   endtask

   task automatic t_wrap();
      int e;
      begin_prog();
      put_w(8'h00, 16'hB908); put_w(8'h02, 16'hC000); put_w(8'h08, 16'h2901);
      put_w(8'h0A, 16'hB0FE); put_w(8'hFE, 16'h275E);
      run(e);
      check("R13 wrap program halts", int'(halted), 1);
      reg_is("R13 instruction at FE ran", 7, 8'h5E);
      reg_is("R13 flag set before wrap", 9, 8'h01);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_load();
      t_reset();
      t_store();
      t_move();
      t_add();
      t_logic();
      t_rot();
      t_jump();
      t_halt();
      t_float();
      t_nop();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule